// File: doc/BRIEF.md
# Vector Memory Address Sequencer

This block turns one vector memory instruction into a stream of per-element byte addresses. A command is taken on a single-cycle `start` while the block is idle. The command carries:

- a base address;
- an access mode;
- a signed stride;
- the raw vector-length value;
- one enable bit per element.

The block then walks the elements in ascending order. For each enabled element it offers an address and the element number to the memory side through a valid/ready handshake. Elements are 64 bits wide, and at most 64 elements make up one vector.

The block has three ways to form an address. Unit stride steps by the element size. Constant stride steps by a signed byte distance. Indexed mode adds a per-element offset, taken from a separate valid/ready index stream, to the base address. A disabled element uses one cycle of the walk but makes no memory request. When the walk ends, the block gives a single-cycle completion pulse.

Top module: `vec_agu`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `req_valid` and `idx_ready` are all low.
- R2: With `mode` 0 (and also the unused code 3) the address of element k is `base + 8*k`, modulo 2^AW.
- R3: With `mode` 1 the address of element k is `base + k*stride`, where `stride` is a two's-complement byte offset, modulo 2^AW.
- R4: With `mode` 2 the address of element k is `base + idx_data`. Exactly one index is consumed for every element below the effective length, including disabled elements.
- R5: Bit k of `mask` enables element k. A disabled element issues no request, but it still advances the element counter. `req_elem` always carries the number k of the element being requested.
- R6: A `vlen` value above 64 is treated as 64.
- R7: A `vlen` of 0 makes the block raise `done` in the cycle after `start`, stay idle and issue no request.
- R8: While `req_valid` is high and `req_ready` is low, the block keeps `req_valid`, `req_addr` and `req_elem` unchanged in the next cycle.
- R9: `done` is a one-cycle pulse. It comes in the cycle after the last element steps, whether that element was accepted or skipped, and `busy` is low with it.
- R10: `start` and all command inputs are ignored while `busy` is high. The command fields are captured only on an idle `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Command strobe, taken only when idle |
| mode | input | 2 | 0 unit stride, 1 constant stride, 2 indexed, 3 as 0 |
| base | input | AW | Base byte address |
| stride | input | AW | Signed byte stride for mode 1 |
| vlen | input | VLW | Raw vector length, clamped to MAXVL |
| mask | input | MAXVL | Per-element enable bits |
| idx_valid | input | 1 | Index stream valid |
| idx_ready | output | 1 | Index stream ready (index consumed) |
| idx_data | input | AW | Byte offset for the current element in mode 2 |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory request accepted |
| req_addr | output | AW | Byte address of the current element |
| req_elem | output | $clog2(MAXVL) | Element number of the current request |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The embedded properties check on every cycle that:

- a stalled request holds its address and element number;
- unit-stride addresses match the element number times eight;
- requested element numbers stay below the clamped length;
- a zero-length command completes in one cycle;
- the captured command does not change while busy.

Only the bench scenarios can show the full address sequences and where they wrap. The same holds for the skipping of disabled elements, the one-to-one consumption of indices even under random gaps, and the exact cycle of the completion pulse after a trailing accepted element.

// File: rtl/vagu_pkg.sv
package vagu_pkg;
    typedef enum logic [1:0] {
        AM_UNIT   = 2'd0,
        AM_STRIDE = 2'd1,
        AM_INDEX  = 2'd2,
        AM_SPARE  = 2'd3
    } amode_e;
endpackage

// File: rtl/vagu_len_clamp.sv
module vagu_len_clamp #(
    parameter int VLW   = 8,
    parameter int MAXVL = 64,
    parameter int CW    = 7
) (
    input  logic [VLW-1:0] vlen_raw,
    output logic [CW-1:0]  vlen_eff
);
    // Saturate the software length at the hardware maximum
    always_comb begin
        if (int'(vlen_raw) > MAXVL) vlen_eff = CW'(MAXVL);
        else                        vlen_eff = CW'(vlen_raw);
    end
endmodule

// File: rtl/vagu_addr_path.sv
module vagu_addr_path
    import vagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int EBYTES = 8
) (
    input  amode_e        mode,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] off,
    input  logic [AW-1:0] stride,
    input  logic [AW-1:0] idx,
    output logic [AW-1:0] addr,
    output logic [AW-1:0] step_amt
);
    // Strided mode advances by the signed stride, the others by one element
    always_comb begin
        step_amt = (mode == AM_STRIDE) ? stride : AW'(EBYTES);
        addr     = base + ((mode == AM_INDEX) ? idx : off);
    end
endmodule

// File: rtl/vec_agu.sv
module vec_agu
    import vagu_pkg::*;
#(
    parameter int AW     = 32,
    parameter int MAXVL  = 64,
    parameter int VLW    = 8,
    parameter int EBYTES = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [1:0]               mode,
    input  logic [AW-1:0]            base,
    input  logic [AW-1:0]            stride,
    input  logic [VLW-1:0]           vlen,
    input  logic [MAXVL-1:0]         mask,
    input  logic                     idx_valid,
    output logic                     idx_ready,
    input  logic [AW-1:0]            idx_data,
    output logic                     req_valid,
    input  logic                     req_ready,
    output logic [AW-1:0]            req_addr,
    output logic [$clog2(MAXVL)-1:0] req_elem,
    output logic                     busy,
    output logic                     done
);
    localparam int EW = $clog2(MAXVL);
    localparam int CW = $clog2(MAXVL + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        amode_e           mode;
        logic [AW-1:0]    base;
        logic [AW-1:0]    stride;
        logic [AW-1:0]    off;
        logic [EW-1:0]    elem;
        logic [CW-1:0]    vl;
        logic [MAXVL-1:0] mask;
    } agu_st_t;

    agu_st_t st_d, st_q;

    logic [CW-1:0] vl_eff;
    logic [AW-1:0] step_amt;
    logic          cur_en;
    logic          have_idx;
    logic          step;
    logic          is_last;

    vagu_len_clamp #(.VLW(VLW), .MAXVL(MAXVL), .CW(CW)) u_clamp (
        .vlen_raw (vlen),
        .vlen_eff (vl_eff)
    );

    vagu_addr_path #(.AW(AW), .EBYTES(EBYTES)) u_addr (
        .mode     (st_q.mode),
        .base     (st_q.base),
        .off      (st_q.off),
        .stride   (st_q.stride),
        .idx      (idx_data),
        .addr     (req_addr),
        .step_amt (step_amt)
    );

    always_comb begin
        cur_en    = st_q.mask[st_q.elem];
        have_idx  = (st_q.mode != AM_INDEX) || idx_valid;
        req_valid = st_q.busy && cur_en && have_idx;
        idx_ready = st_q.busy && (st_q.mode == AM_INDEX) && (!cur_en || req_ready);
        step      = st_q.busy && have_idx && (!cur_en || req_ready);
        is_last   = (CW'(st_q.elem) + CW'(1)) == st_q.vl;

        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy && start) begin
            st_d.mode   = amode_e'(mode);
            st_d.base   = base;
            st_d.stride = stride;
            st_d.vl     = vl_eff;
            st_d.mask   = mask;
            st_d.off    = '0;
            st_d.elem   = '0;
            if (vl_eff == '0) st_d.done = 1'b1;
            else              st_d.busy = 1'b1;
        end else if (step) begin
            if (is_last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.elem = st_q.elem + EW'(1);
                st_d.off  = st_q.off + step_amt;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_elem = st_q.elem;
    assign busy     = st_q.busy;
    assign done     = st_q.done;

    // R8: a request not taken is offered again unchanged
    a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_elem)));

    // R2: unit-stride address equals base plus element number times element size
    a_r2_unit_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (st_q.mode == AM_UNIT)) |-> (req_addr == st_q.base + AW'(st_q.elem) * AW'(EBYTES)));

    // R6: requested elements stay inside the clamped length
    a_r6_elem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> ((CW'(req_elem) < st_q.vl) && (st_q.vl <= CW'(MAXVL))));

    // R7: zero length completes on the next cycle without going busy
    a_r7_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && (vl_eff == '0)) |=> (done && !busy));

    // R9: completion pulse coincides with idle and no request
    a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !req_valid));

    // R10: captured command stays put while busy
    a_r10_cmd_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> ($stable(st_q.base) && $stable(st_q.mode) && $stable(st_q.vl)));
endmodule

// File: tb/vec_agu_tb_top.sv
`timescale 1ns/1ps
module vec_agu_tb_top;
    localparam int AW    = 32;
    localparam int MAXVL = 64;
    localparam int VLW   = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [1:0]       mode = '0;
    logic [AW-1:0]    base = '0;
    logic [AW-1:0]    stride = '0;
    logic [VLW-1:0]   vlen = '0;
    logic [MAXVL-1:0] mask = '0;
    logic             idx_valid = 1'b0;
    logic             idx_ready;
    logic [AW-1:0]    idx_data = '0;
    logic             req_valid;
    logic             req_ready = 1'b0;
    logic [AW-1:0]    req_addr;
    logic [5:0]       req_elem;
    logic             busy;
    logic             done;

    int n_cmp = 0;
    int n_bad = 0;

    logic [AW-1:0] exp_addr[$];
    int            exp_elem[$];
    logic [AW-1:0] idx_q[$];

    always #2.5 clk = ~clk;

    vec_agu #(.AW(AW), .MAXVL(MAXVL), .VLW(VLW), .EBYTES(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .base(base),
        .stride(stride), .vlen(vlen), .mask(mask), .idx_valid(idx_valid),
        .idx_ready(idx_ready), .idx_data(idx_data), .req_valid(req_valid),
        .req_ready(req_ready), .req_addr(req_addr), .req_elem(req_elem),
        .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic run_op(input int md, input logic [AW-1:0] b, input logic [AW-1:0] s,
                          input int vl, input logic [MAXVL-1:0] m, input int rdy_pct,
                          input int idx_pct, input bit poke, input string tag);
        int            eff;
        int            cycles;
        bit            seen_done;
        bit            stall_prev;
        logic [AW-1:0] stall_addr;
        logic [5:0]    stall_elem;
        int            prev_hs;
        bit            idx_hold;
        logic [AW-1:0] a;
        logic [AW-1:0] ix;
        eff = (vl > MAXVL) ? MAXVL : vl;
        exp_addr.delete(); exp_elem.delete(); idx_q.delete();
        for (int k = 0; k < eff; k++) begin
            ix = $urandom;
            if (md == 2) idx_q.push_back(ix);
            if (md == 1)      a = b + AW'(k) * s;
            else if (md == 2) a = b + ix;
            else              a = b + AW'(k) * 32'd8;
            if (m[k]) begin
                exp_addr.push_back(a);
                exp_elem.push_back(k);
            end
        end
        @(negedge clk);
        start = 1'b1; mode = md[1:0]; base = b; stride = s; vlen = VLW'(vl); mask = m;
        req_ready = 1'b0; idx_valid = 1'b0;
        @(negedge clk);
        start = 1'b0; base = 32'hDEAD_0000; stride = 32'h1234; mode = 2'd1; mask = ~m;
        if (eff == 0) begin
            #1;
            chk(done === 1'b1 && busy === 1'b0, "R7", "done after zero length", {busy, done}, 2'b01);
            chk(req_valid === 1'b0, "R7", "no request on zero length", req_valid, 0);
            @(negedge clk);
            #1;
            chk(done === 1'b0, "R9", "done pulse width", done, 0);
            return;
        end
        cycles = 0; seen_done = 0; stall_prev = 0; prev_hs = -1; idx_hold = 0;
        stall_addr = '0; stall_elem = '0;
        while (cycles < 3000) begin
            req_ready = (($urandom % 100) < rdy_pct);
            if (!idx_hold)
                idx_valid = (md == 2) && (idx_q.size() > 0) && (($urandom % 100) < idx_pct);
            idx_data = (idx_q.size() > 0) ? idx_q[0] : '0;
            if (poke && (cycles == 3)) start = 1'b1;
            else                       start = 1'b0;
            #1;
            if (done) begin
                seen_done = 1;
                chk(busy === 1'b0, "R9", "busy low with done", busy, 0);
                chk(exp_addr.size() == 0, tag, "requests left at done", exp_addr.size(), 0);
                chk(idx_q.size() == 0, "R4", "indices left at done", idx_q.size(), 0);
                if (m[eff-1])
                    chk(prev_hs == eff - 1, "R9", "done follows last accept", prev_hs, eff - 1);
                break;
            end
            if (stall_prev)
                chk(req_valid === 1'b1 && req_addr == stall_addr && req_elem == stall_elem,
                    "R8", "stalled request held", {req_valid, req_elem, req_addr},
                    {1'b1, stall_elem, stall_addr});
            prev_hs = -1;
            if (req_valid && req_ready) begin
                if (exp_addr.size() == 0) begin
                    chk(0, tag, "unexpected request", req_addr, 0);
                end else begin
                    chk(req_addr == exp_addr[0], tag, "address", req_addr, exp_addr[0]);
                    chk(int'(req_elem) == exp_elem[0], tag, "element number", req_elem, exp_elem[0]);
                    void'(exp_addr.pop_front());
                    void'(exp_elem.pop_front());
                end
                prev_hs = int'(req_elem);
            end
            stall_prev = req_valid && !req_ready;
            stall_addr = req_addr;
            stall_elem = req_elem;
            idx_hold   = idx_valid && !idx_ready;
            if (idx_valid && idx_ready) void'(idx_q.pop_front());
            @(negedge clk);
            cycles++;
        end
        start = 1'b0;
        idx_valid = 1'b0;
        if (!seen_done) chk(0, "R9", "done never seen", 0, 1);
        @(negedge clk);
        #1;
        chk(done === 1'b0 && req_valid === 1'b0, "R9", "single done pulse", {done, req_valid}, 0);
    endtask

    initial begin
        #(200000 * 5);
        n_cmp++;
        n_bad++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(busy === 1'b0 && done === 1'b0 && req_valid === 1'b0 && idx_ready === 1'b0,
            "R1", "idle in reset", {busy, done, req_valid, idx_ready}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(busy === 1'b0 && done === 1'b0 && req_valid === 1'b0, "R1", "idle after reset",
            {busy, done, req_valid}, 0);

        run_op(0, 32'h0000_1000, 0, 16, {MAXVL{1'b1}}, 100, 100, 0, "R2");
        run_op(0, 32'hFFFF_FFC0, 0, 20, {MAXVL{1'b1}}, 40, 100, 0, "R8");
        run_op(3, 32'h0000_2000, 0, 6, {MAXVL{1'b1}}, 80, 100, 0, "R2");
        run_op(1, 32'h0000_0400, 32'd24, 10, {MAXVL{1'b1}}, 70, 100, 0, "R3");
        run_op(1, 32'h0000_0100, -32'sd16, 30, {MAXVL{1'b1}}, 60, 100, 0, "R3");
        run_op(1, 32'h0000_0800, 32'd0, 5, {MAXVL{1'b1}}, 100, 100, 0, "R3");
        run_op(2, 32'h4000_0000, 0, 16, {MAXVL{1'b1}}, 70, 60, 0, "R4");
        run_op(2, 32'h0001_0000, 0, 24, 64'h0000_0000_00A5_3C81, 50, 50, 0, "R5");
        run_op(0, 32'h0000_3000, 0, 12, 64'h0000_0000_0000_0AAA, 100, 100, 0, "R5");
        run_op(0, 32'h0000_5000, 0, 8, 64'h0, 100, 100, 0, "R5");
        run_op(0, 32'h0000_6000, 0, 200, {MAXVL{1'b1}}, 90, 100, 0, "R6");
        run_op(1, 32'h0000_7000, 32'd40, 65, {MAXVL{1'b1}}, 90, 100, 0, "R6");
        run_op(0, 32'h0000_8000, 0, 64, {1'b1, {(MAXVL-1){1'b0}}}, 100, 100, 0, "R6");
        run_op(0, 32'h0000_9000, 0, 0, {MAXVL{1'b1}}, 100, 100, 0, "R7");
        run_op(2, 32'h0000_A000, 0, 0, {MAXVL{1'b1}}, 100, 100, 0, "R7");
        run_op(1, 32'h0000_B000, 32'd8, 30, {MAXVL{1'b1}}, 50, 100, 1, "R10");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule